// File: doc/BRIEF.md
# SCSI Initiator Information-Phase Byte Mover

This block carries bytes across the asynchronous REQ/ACK handshake of the SCSI information phases, on the initiator side. A start pulse captures the phase the target is currently signalling on the three control lines MSG, C/D and I/O, taken as a 3-bit code with MSG as the top bit. Bit 0 (I/O) of that code sets the direction. The start pulse also loads a transfer count. After that, every REQ from the target moves one byte between the bus and a single-byte data register. This continues until the count runs out or the target switches to a different phase. At that point the block goes idle and raises a bus-service flag.

The data register can be filled or emptied in two ways. In DMA mode the block raises a request and waits for a read or write strobe. Otherwise the host uses plain register read and write pulses. A pad mode handles filler traffic: incoming bytes are thrown away and the byte already held is sent again for every REQ, with no DMA involvement. Two message-phase details are handled inside the block:
- On the final message-in byte, ACK is left asserted so the host can inspect the message before releasing ACK.
- On the final message-out byte, ATN is dropped in the same cycle that ACK goes up.

Top module: `scsi_xfer_engine`

## Requirements
- R1: After reset, ACK, ATN, DMA request, data-full, busy, bus-service and function-complete are all low, the count is 0, and the terminal-count flag is high.
- R2: A start pulse while idle does five things: it captures `bus_phase_i`, loads `count_in`, clears data-full, clears both completion flags and sets busy. Phase bit 0 = 1 selects input, and 0 selects output. The phase codes are 0 data out, 1 data in, 2 command, 3 status, 6 message out and 7 message in.
- R3: A REQ that arrives while the count is 0, or while `bus_phase_i` differs from the captured phase, moves no byte and leaves ACK low. The block goes idle with bus-service set.
- R4: Input in DMA mode works as follows. On REQ the bus byte is latched into the data register, data-full is set and the DMA request is raised. ACK rises only after data-full has been cleared.
- R5: Output works as follows. On REQ the DMA request is raised (in DMA mode) and the block waits for a byte. It then drives that byte on `bus_data_o` with ACK high and clears data-full. When REQ falls, it releases ACK and returns the data lines to 0.
- R6: The count decrements by one each time REQ falls while ACK is high, and only in DMA mode. When it reaches 0, the terminal-count flag is set.
- R7: The count can reach 0 on a message-in byte (phase 7). In that case ACK stays high after REQ falls, function-complete is set and the block goes idle. `ack_release` then drops ACK. In every other case ACK is released when REQ falls.
- R8: During an output byte in message-out phase (6) with the count at 1, ATN falls in the same cycle that ACK rises. `atn_set` raises ATN.
- R9: In pad mode no DMA request is ever raised. An input byte is acknowledged without being latched, so data-full stays unchanged. An output byte drives the value held in the data register for every REQ.
- R10: The DMA request falls on the clock edge that samples its matching strobe. A DMA strobe while no request is pending leaves the data register and data-full unchanged.
- R11: A host read pulse clears data-full. A host write is accepted only when data-full is low and no input byte is in progress, so a write into a full register is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (only acted on while idle) |
| count_in | input | CNT_W | Transfer count loaded at start |
| dma_mode | input | 1 | Bytes are moved by the DMA strobes; enables count decrement |
| pad_mode | input | 1 | Discard input / repeat held output, no DMA |
| atn_set | input | 1 | Raise ATN |
| ack_release | input | 1 | Drop an ACK held after the last message-in byte |
| bus_req_i | input | 1 | REQ from target |
| bus_phase_i | input | 3 | {MSG, C/D, I/O} from target |
| bus_data_i | input | DW | Bus data from target |
| bus_ack_o | output | 1 | ACK to target |
| bus_atn_o | output | 1 | ATN to target |
| bus_data_o | output | DW | Bus data to target (0 when not driving) |
| host_wr | input | 1 | Host write pulse into the data register |
| host_wdata | input | DW | Host write data |
| host_rd | input | 1 | Host read pulse, empties the data register |
| data_reg_o | output | DW | Data register contents |
| data_full | output | 1 | Data register holds an unconsumed byte |
| dma_req | output | 1 | DMA request |
| dma_rd | input | 1 | DMA read strobe (input direction) |
| dma_wr | input | 1 | DMA write strobe (output direction) |
| dma_wdata | input | DW | DMA write data |
| busy | output | 1 | Transfer in progress |
| bus_service | output | 1 | Stopped on count end or phase change |
| func_complete | output | 1 | Last message-in byte taken, ACK held |
| tc_zero | output | 1 | Count is zero |
| count_o | output | CNT_W | Remaining count |

## Verification
A wrong state register shows up on the bus within one handshake. Either ACK rises before the DMA request has been serviced, or it fails to rise or fall on the REQ edge the bench is polling for. That missed edge times out the bench's bounded wait. A wrong captured phase or a wrong count shows at the terminating REQ, as bus-service arriving one byte early or late. It also shows as `count_o` and the terminal-count flag not matching the bench's expected value. The message-phase corner cases can only be seen in one cycle each: the level of ATN when ACK rises, and the level of ACK once REQ falls on the final message-in byte. The bench samples exactly those instants.

// File: rtl/scsi_xfer_engine.sv
module scsi_xfer_engine #(
  parameter int CNT_W = 24,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count_in,
  input  logic             dma_mode,
  input  logic             pad_mode,
  input  logic             atn_set,
  input  logic             ack_release,
  input  logic             bus_req_i,
  input  logic [2:0]       bus_phase_i,
  input  logic [DW-1:0]    bus_data_i,
  output logic             bus_ack_o,
  output logic             bus_atn_o,
  output logic [DW-1:0]    bus_data_o,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             host_rd,
  output logic [DW-1:0]    data_reg_o,
  output logic             data_full,
  output logic             dma_req,
  input  logic             dma_rd,
  input  logic             dma_wr,
  input  logic [DW-1:0]    dma_wdata,
  output logic             busy,
  output logic             bus_service,
  output logic             func_complete,
  output logic             tc_zero,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [2:0] PH_MSG_OUT = 3'd6;
  localparam logic [2:0] PH_MSG_IN  = 3'd7;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_IN_REQ, S_IN_WAIT, S_IN_ACK, S_OUT_REQ, S_OUT_WAIT, S_OUT_ACK
  } st_t;

  st_t              state;
  logic [2:0]       phase_q;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    dreg;

  wire in_side   = (state == S_IN_REQ) || (state == S_IN_WAIT) || (state == S_IN_ACK);
  wire move_ok   = (cnt != '0) && (bus_phase_i == phase_q);
  wire dma_take  = dma_rd && dma_req && data_full;
  wire dma_give  = dma_wr && dma_req && !data_full;
  wire host_take = host_rd && data_full;
  wire host_give = host_wr && !data_full && !in_side;
  wire last_byte = (cnt == CNT_ONE);
  wire hold_ack  = dma_mode && last_byte && (bus_phase_i == PH_MSG_IN);
  wire drop_atn  = last_byte && (bus_phase_i == PH_MSG_OUT);

  assign busy       = (state != S_IDLE);
  assign count_o    = cnt;
  assign data_reg_o = dreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      phase_q       <= '0;
      cnt           <= '0;
      dreg          <= '0;
      data_full     <= 1'b0;
      dma_req       <= 1'b0;
      bus_ack_o     <= 1'b0;
      bus_atn_o     <= 1'b0;
      bus_data_o    <= '0;
      bus_service   <= 1'b0;
      func_complete <= 1'b0;
      tc_zero       <= 1'b1;
    end else begin
      if (atn_set) bus_atn_o <= 1'b1;

      if (host_take) data_full <= 1'b0;
      if (dma_take) begin
        data_full <= 1'b0;
        dma_req   <= 1'b0;
      end
      if (host_give) begin
        dreg      <= host_wdata;
        data_full <= 1'b1;
      end
      if (dma_give) begin
        dreg      <= dma_wdata;
        data_full <= 1'b1;
        dma_req   <= 1'b0;
      end

      unique case (state)
        S_IDLE: begin
          if (ack_release) bus_ack_o <= 1'b0;
          if (start) begin
            phase_q       <= bus_phase_i;
            cnt           <= count_in;
            tc_zero       <= (count_in == '0);
            bus_service   <= 1'b0;
            func_complete <= 1'b0;
            data_full     <= 1'b0;
            state         <= bus_phase_i[0] ? S_IN_REQ : S_OUT_REQ;
          end
        end

        S_IN_REQ: begin
          if (bus_req_i) begin
            if (move_ok) begin
              if (pad_mode) begin
                bus_ack_o <= 1'b1;
                state     <= S_IN_ACK;
              end else begin
                dreg      <= bus_data_i;
                data_full <= 1'b1;
                dma_req   <= dma_mode;
                state     <= S_IN_WAIT;
              end
            end else begin
              bus_service <= 1'b1;
              state       <= S_IDLE;
            end
          end
        end

        S_IN_WAIT: begin
          if (!data_full) begin
            bus_ack_o <= 1'b1;
            state     <= S_IN_ACK;
          end
        end

        S_IN_ACK: begin
          if (!bus_req_i) begin
            if (dma_mode) begin
              cnt <= cnt - CNT_ONE;
              if (last_byte) tc_zero <= 1'b1;
            end
            if (hold_ack) begin
              func_complete <= 1'b1;
              state         <= S_IDLE;
            end else begin
              bus_ack_o <= 1'b0;
              state     <= S_IN_REQ;
            end
          end
        end

        S_OUT_REQ: begin
          if (bus_req_i) begin
            if (move_ok) begin
              if (pad_mode) begin
                bus_data_o <= dreg;
                bus_ack_o  <= 1'b1;
                data_full  <= 1'b0;
                if (drop_atn) bus_atn_o <= 1'b0;
                state      <= S_OUT_ACK;
              end else begin
                dma_req <= dma_mode;
                state   <= S_OUT_WAIT;
              end
            end else begin
              bus_service <= 1'b1;
              state       <= S_IDLE;
            end
          end
        end

        S_OUT_WAIT: begin
          if (data_full) begin
            bus_data_o <= dreg;
            bus_ack_o  <= 1'b1;
            data_full  <= 1'b0;
            if (drop_atn) bus_atn_o <= 1'b0;
            state      <= S_OUT_ACK;
          end
        end

        S_OUT_ACK: begin
          if (!bus_req_i) begin
            if (dma_mode) begin
              cnt <= cnt - CNT_ONE;
              if (last_byte) tc_zero <= 1'b1;
            end
            bus_ack_o  <= 1'b0;
            bus_data_o <= '0;
            state      <= S_OUT_REQ;
          end
        end

        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scsi_xfer_engine_chk.sv
module scsi_xfer_engine_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             bus_ack_o,
  input logic             bus_atn_o,
  input logic             dma_req,
  input logic             dma_rd,
  input logic             dma_wr,
  input logic             data_full,
  input logic             busy,
  input logic             bus_service,
  input logic             func_complete,
  input logic             tc_zero,
  input logic [CNT_W-1:0] count_o
);

  a_r3_stop_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_service) |-> !busy);

  a_r4_ack_after_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack_o) |-> !data_full);

  a_r6_count_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (count_o == $past(count_o)) || (count_o == $past(count_o) - CNT_W'(1)));

  a_r6_tc_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tc_zero |-> (count_o == '0));

  a_r7_fc_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(func_complete) |-> (bus_ack_o && !busy));

  a_r8_atn_drops_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_atn_o) |-> $rose(bus_ack_o));

  a_r10_rd_strobe_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_rd && data_full) |=> !dma_req);

  a_r10_wr_strobe_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_wr && !data_full) |=> !dma_req);

endmodule

bind scsi_xfer_engine scsi_xfer_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .bus_ack_o     (bus_ack_o),
  .bus_atn_o     (bus_atn_o),
  .dma_req       (dma_req),
  .dma_rd        (dma_rd),
  .dma_wr        (dma_wr),
  .data_full     (data_full),
  .busy          (busy),
  .bus_service   (bus_service),
  .func_complete (func_complete),
  .tc_zero       (tc_zero),
  .count_o       (count_o)
);

// File: tb/scsi_xfer_engine_tb.sv
module scsi_xfer_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 24;
  localparam int DW = 8;
  localparam int NV = 8;
  // {phase[2:0], count[7:0], bytes offered by target[7:0]}
  localparam logic [18:0] VEC [NV] = '{
    {3'd1, 8'd3, 8'd3},
    {3'd0, 8'd2, 8'd4},
    {3'd2, 8'd4, 8'd2},
    {3'd3, 8'd1, 8'd1},
    {3'd7, 8'd1, 8'd1},
    {3'd6, 8'd2, 8'd2},
    {3'd7, 8'd3, 8'd2},
    {3'd1, 8'd5, 8'd5}
  };

  logic clk = 0, rst_n = 0;
  logic start = 0, dma_mode = 0, pad_mode = 0, atn_set = 0, ack_release = 0;
  logic [CNT_W-1:0] count_in = '0;
  logic bus_req_i = 0;
  logic [2:0] bus_phase_i = '0;
  logic [DW-1:0] bus_data_i = '0, host_wdata = '0, dma_wdata = '0;
  logic host_wr = 0, host_rd = 0, dma_rd = 0, dma_wr = 0;
  logic bus_ack_o, bus_atn_o, data_full, dma_req, busy, bus_service, func_complete, tc_zero;
  logic [DW-1:0] bus_data_o, data_reg_o;
  logic [CNT_W-1:0] count_o;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_xfer_engine #(.CNT_W(CNT_W), .DW(DW)) u_dut (.*);

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish (actual=timeout expected=done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return bus_ack_o;
      1: return dma_req;
      2: return busy;
      default: return data_full;
    endcase
  endfunction

  task automatic wait_for(input int sel, input logic val, output bit ok);
    ok = 0;
    for (int i = 0; i < 60; i++) begin
      if (sig(sel) == val) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic pulse_start(input logic [2:0] ph, input int cnt);
    bus_phase_i = ph; count_in = CNT_W'(cnt); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic byte_in(input logic [2:0] ph, input logic [7:0] d, input bit dma, input bit hold, input string tag);
    bit ok;
    bus_phase_i = ph; bus_data_i = d; bus_req_i = 1;
    if (dma) begin
      wait_for(1, 1, ok);
      chk(ok, {tag, " R4 dma_req raised"}, ok, 1);
      chk(data_reg_o == d && data_full && !bus_ack_o, {tag, " R4 byte latched, ACK low"}, data_reg_o, d);
      dma_rd = 1; @(negedge clk); dma_rd = 0;
      chk(!dma_req, {tag, " R10 dma_req drops after strobe"}, dma_req, 0);
    end else begin
      wait_for(3, 1, ok);
      chk(ok && !dma_req && data_reg_o == d, {tag, " R11 host byte, no dma_req"}, data_reg_o, d);
      host_rd = 1; @(negedge clk); host_rd = 0;
    end
    wait_for(0, 1, ok);
    chk(ok, {tag, " R4 ACK after byte taken"}, bus_ack_o, 1);
    bus_req_i = 0;
    if (hold) begin
      wait_for(2, 0, ok);
      chk(bus_ack_o && func_complete, {tag, " R7 ACK held, function-complete"}, {bus_ack_o, func_complete}, 2'b11);
    end else begin
      wait_for(0, 0, ok);
      chk(ok, {tag, " R5 ACK released on REQ fall"}, bus_ack_o, 0);
    end
  endtask

  task automatic byte_out(input logic [2:0] ph, input logic [7:0] d, input bit exp_atn, input string tag);
    bit ok;
    bus_phase_i = ph; bus_req_i = 1;
    wait_for(1, 1, ok);
    chk(ok && !bus_ack_o, {tag, " R5 dma_req before ACK"}, dma_req, 1);
    dma_wr = 1; dma_wdata = d; @(negedge clk); dma_wr = 0;
    chk(!dma_req, {tag, " R10 dma_req drops after write strobe"}, dma_req, 0);
    wait_for(0, 1, ok);
    chk(ok && bus_data_o == d, {tag, " R5 data driven with ACK"}, bus_data_o, d);
    chk(bus_atn_o == exp_atn, {tag, " R8 ATN level at ACK"}, bus_atn_o, exp_atn);
    bus_req_i = 0;
    wait_for(0, 0, ok);
    chk(ok && bus_data_o == 0, {tag, " R5 ACK/data released"}, bus_data_o, 0);
  endtask

  task automatic pad_byte(input logic [2:0] ph, input logic [7:0] exp_d, input string tag);
    bit ok;
    bus_phase_i = ph; bus_data_i = 8'hEE; bus_req_i = 1;
    wait_for(0, 1, ok);
    chk(ok && !dma_req, {tag, " R9 pad ACK without DMA"}, dma_req, 0);
    if (!ph[0]) chk(bus_data_o == exp_d, {tag, " R9 pad repeats held byte"}, bus_data_o, exp_d);
    else chk(!data_full && data_reg_o != 8'hEE, {tag, " R9 pad input discarded"}, data_reg_o, 0);
    bus_req_i = 0;
    wait_for(0, 0, ok);
  endtask

  task automatic terminate(input logic [2:0] ph, input string tag);
    bit ok;
    bus_phase_i = ph; bus_req_i = 1;
    wait_for(2, 0, ok);
    chk(ok && bus_service && !bus_ack_o, {tag, " R3 stop with bus-service"}, {bus_service, bus_ack_o}, 2'b10);
    bus_req_i = 0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk(!bus_ack_o && !bus_atn_o && !dma_req && !data_full && !busy && !bus_service
        && !func_complete && count_o == 0 && tc_zero, "R1 reset state",
        {bus_ack_o, bus_atn_o, dma_req, data_full, busy, tc_zero}, 6'b000001);
    rst_n = 1;
    @(negedge clk);

    dma_mode = 1;
    for (int v = 0; v < NV; v++) begin
      automatic logic [2:0] ph = VEC[v][18:16];
      automatic int cnt = int'(VEC[v][15:8]);
      automatic int nreq = int'(VEC[v][7:0]);
      automatic int moved = (cnt < nreq) ? cnt : nreq;
      automatic bit hold = (ph == 3'd7) && (moved == cnt);
      automatic string tag = $sformatf("vec%0d", v);
      if (ph == 3'd6) begin atn_set = 1; @(negedge clk); atn_set = 0; end
      pulse_start(ph, cnt);
      chk(busy && !data_full, {tag, " R2 busy after start"}, busy, 1);
      for (int k = 0; k < moved; k++) begin
        automatic logic [7:0] d = 8'(8'h10 * v + k + 1);
        if (ph[0]) byte_in(ph, d, 1, hold && (k == moved - 1), tag);
        else byte_out(ph, d, (ph == 3'd6) && (k != cnt - 1), tag);
      end
      chk(count_o == CNT_W'(cnt - moved) && tc_zero == (cnt == moved), {tag, " R6 count and tc_zero"},
          count_o, cnt - moved);
      if (hold) begin
        ack_release = 1; @(negedge clk); ack_release = 0; @(negedge clk);
        chk(!bus_ack_o, {tag, " R7 ack_release drops ACK"}, bus_ack_o, 0);
      end else begin
        terminate((moved == cnt) ? ph : ((ph == 3'd3) ? 3'd2 : 3'd3), tag);
      end
    end

    // R6: no decrement without DMA mode; host path (R11)
    dma_mode = 0;
    pulse_start(3'd1, 2);
    byte_in(3'd1, 8'h3C, 0, 0, "nodma");
    chk(count_o == 2 && !tc_zero, "R6 count unchanged without DMA mode", count_o, 2);
    terminate(3'd3, "nodma");

    // R3: count zero at start stops on first REQ
    pulse_start(3'd1, 0);
    terminate(3'd1, "zero-count R3");

    // R11: host write ignored when full, read empties
    host_wr = 1; host_wdata = 8'h11; @(negedge clk);
    host_wdata = 8'h22; @(negedge clk); host_wr = 0;
    chk(data_reg_o == 8'h11 && data_full, "R11 write into full register ignored", data_reg_o, 8'h11);
    // R10: stray strobes ignored
    dma_rd = 1; @(negedge clk); dma_rd = 0;
    chk(data_full && data_reg_o == 8'h11, "R10 stray read strobe ignored", data_full, 1);
    host_rd = 1; @(negedge clk); host_rd = 0;
    chk(!data_full, "R11 host read clears data-full", data_full, 0);
    dma_wr = 1; dma_wdata = 8'h77; @(negedge clk); dma_wr = 0;
    chk(!data_full && data_reg_o == 8'h11, "R10 stray write strobe ignored", data_reg_o, 8'h11);

    // R9: pad output repeats held byte, pad input discards
    dma_mode = 1; pad_mode = 1;
    host_wr = 1; host_wdata = 8'h5A; @(negedge clk); host_wr = 0;
    pulse_start(3'd0, 2);
    pad_byte(3'd0, 8'h5A, "padout");
    pad_byte(3'd0, 8'h5A, "padout");
    chk(count_o == 0 && tc_zero, "R9 pad output counted", count_o, 0);
    terminate(3'd0, "padout");
    pulse_start(3'd1, 2);
    pad_byte(3'd1, 8'h00, "padin");
    pad_byte(3'd1, 8'h00, "padin");
    chk(count_o == 0 && data_reg_o == 8'h5A, "R9 pad input left register", data_reg_o, 8'h5A);
    terminate(3'd1, "padin");
    pad_mode = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule